// File: doc/BRIEF.md
# CPU Clock Domain Control Register Block

This block is the register-level model of the controller that selects and divides the clocks of a CPU domain. A frequency-change sequencer or software reaches it over a plain single-cycle read/write bus. It holds a source-select register with two mux selects: the core clock source and the performance-monitor clock source. It also holds two divider-control registers of 3-bit ratio fields, and three read-only status registers. No clock is actually generated here. The block models how long each change takes to settle, so that the agent driving it has a completion handshake to poll.

Each write that changes a mux select starts a transition. The status field for that mux reads an "in progress" code for `MUX_SETTLE_CYC` cycles and then shows which source is in use. Each write that changes a divider ratio field raises that field's busy bit for `DIV_SETTLE_CYC` cycles. A field that a write leaves unchanged raises nothing. A changed write that arrives while a change is still settling starts the settling time again from that write.

Top module: `cpuclk_ctl_regs`

## Requirements
- R1: After reset the source register reads 0, the mux status register reads 0x0011_0000 (both mux fields show code 1, primary), both divider registers read 0 and both divider status registers read 0.
- R2: Register offsets are: source select 0x000, mux status 0x200, divider A 0x300, divider B 0x304, divider A status 0x400, divider B status 0x404. The source register keeps only bit 16 (core select) and bit 20 (monitor select). Divider A holds seven 3-bit fields at bits 0,4,8,12,16,20,24. Divider B holds two 3-bit fields at bits 0 and 4. All other bits read 0.
- R3: Writing a bit 16 that differs from the current core select makes mux status bits [18:16] read 4 for exactly `MUX_SETTLE_CYC` cycles after the write edge. After that they read 1 when bit 16 is 0 and 2 when it is 1.
- R4: The monitor select at bit 20 behaves like R3, with its status in bits [22:20] and independent of the core mux.
- R5: A source write that leaves a select unchanged starts no transition for that mux.
- R6: A write that changes a divider field sets that field's busy bit to 1 for exactly `DIV_SETTLE_CYC` cycles after the write edge, then 0. The busy bit sits in the matching status register at the field's lowest bit position. Only fields whose value changed go busy.
- R7: A divider write that leaves a field's value unchanged raises no busy bit for it.
- R8: A changing write to a field or mux that is still settling restarts its full settle time from the new write and targets the new value.
- R9: Writes to the three status offsets are ignored: status and control registers read back unchanged.
- R10: Reads of undefined offsets return 0 and writes to them change no register.
- R11: `rdata` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` while `rd_en` is high |

## Verification
Two functions can fall in the same cycle: a field finishing its countdown and a new changing write to that same field. The bench provokes this by issuing the second write in the last busy cycle of the first, for both a divider field and the core mux. It then judges that the busy indication lasts the full settle time counted from the second write and ends on the second value. A single source write that flips both mux selects at once also checks that the two mux trackers settle on their own fields in the same cycles.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;

    localparam int DATA_W       = 32;
    localparam int FIELD_W      = 3;
    localparam int FIELD_STRIDE = 4;
    localparam int DIVA_FIELDS  = 7;
    localparam int DIVB_FIELDS  = 2;
    localparam int MUX_COUNT    = 2;
    localparam int MUX_BASE_BIT = 16;

    localparam logic [11:0] OFF_SRC    = 12'h000;
    localparam logic [11:0] OFF_MSTAT  = 12'h200;
    localparam logic [11:0] OFF_DIVA   = 12'h300;
    localparam logic [11:0] OFF_DIVB   = 12'h304;
    localparam logic [11:0] OFF_DSTATA = 12'h400;
    localparam logic [11:0] OFF_DSTATB = 12'h404;

    typedef enum logic [FIELD_W-1:0] {
        MSTAT_PRIMARY = 3'd1,
        MSTAT_ALT     = 3'd2,
        MSTAT_MOVING  = 3'd4
    } mux_stat_e;

    typedef struct packed {
        logic src;
        logic mstat;
        logic diva;
        logic divb;
        logic dstata;
        logic dstatb;
    } reg_hit_t;

endpackage

// File: rtl/cpuclk_addr_dec.sv
module cpuclk_addr_dec
    import cpuclk_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_hit_t          hit
);

    always_comb begin
        hit        = '0;
        hit.src    = (addr == ADDR_W'(OFF_SRC));
        hit.mstat  = (addr == ADDR_W'(OFF_MSTAT));
        hit.diva   = (addr == ADDR_W'(OFF_DIVA));
        hit.divb   = (addr == ADDR_W'(OFF_DIVB));
        hit.dstata = (addr == ADDR_W'(OFF_DSTATA));
        hit.dstatb = (addr == ADDR_W'(OFF_DSTATB));
    end

endmodule

// File: rtl/cpuclk_mux_track.sv
module cpuclk_mux_track
    import cpuclk_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_sel,
    output logic               sel,
    output logic [FIELD_W-1:0] stat
);

    localparam int CW = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        logic          sel;
        logic [CW-1:0] cnt;
    } mux_state_t;

    mux_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (wr_en && (wr_sel != st_q.sel)) begin
            st_d.sel = wr_sel;
            st_d.cnt = CW'(SETTLE_CYC);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (st_q.cnt != '0) begin
            stat = MSTAT_MOVING;
        end else if (st_q.sel) begin
            stat = MSTAT_ALT;
        end else begin
            stat = MSTAT_PRIMARY;
        end
    end

    assign sel = st_q.sel;

endmodule

// File: rtl/cpuclk_div_field.sv
module cpuclk_div_field
    import cpuclk_pkg::*;
#(
    parameter int SETTLE_CYC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wr_val,
    output logic [FIELD_W-1:0] val,
    output logic               busy
);

    localparam int CW = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        logic [FIELD_W-1:0] val;
        logic [CW-1:0]      cnt;
    } div_state_t;

    div_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (wr_en && (wr_val != st_q.val)) begin
            st_d.val = wr_val;
            st_d.cnt = CW'(SETTLE_CYC);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign val  = st_q.val;
    assign busy = (st_q.cnt != '0);

endmodule

// File: rtl/cpuclk_ctl_regs.sv
module cpuclk_ctl_regs
    import cpuclk_pkg::*;
#(
    parameter int ADDR_W         = 12,
    parameter int MUX_SETTLE_CYC = 4,
    parameter int DIV_SETTLE_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int MUX_STAT_W = MUX_COUNT * FIELD_W;
    localparam int DIVA_VAL_W = DIVA_FIELDS * FIELD_W;
    localparam int DIVB_VAL_W = DIVB_FIELDS * FIELD_W;

    reg_hit_t hit;

    logic [MUX_COUNT-1:0]   msel;
    logic [MUX_STAT_W-1:0]  mstat;
    logic [DIVA_VAL_W-1:0]  diva_val;
    logic [DIVA_FIELDS-1:0] diva_busy;
    logic [DIVB_VAL_W-1:0]  divb_val;
    logic [DIVB_FIELDS-1:0] divb_busy;
    logic [DATA_W-1:0]      rd_word;
    logic                   unused_wbits;

    assign unused_wbits = ^wdata;

    cpuclk_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .hit  (hit)
    );

    for (genvar m = 0; m < MUX_COUNT; m++) begin : g_mux
        localparam int POS = MUX_BASE_BIT + m * FIELD_STRIDE;
        cpuclk_mux_track #(.SETTLE_CYC(MUX_SETTLE_CYC)) u_mux (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en && hit.src),
            .wr_sel (wdata[POS]),
            .sel    (msel[m]),
            .stat   (mstat[m*FIELD_W +: FIELD_W])
        );
    end

    for (genvar a = 0; a < DIVA_FIELDS; a++) begin : g_diva
        cpuclk_div_field #(.SETTLE_CYC(DIV_SETTLE_CYC)) u_fld (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en && hit.diva),
            .wr_val (wdata[a*FIELD_STRIDE +: FIELD_W]),
            .val    (diva_val[a*FIELD_W +: FIELD_W]),
            .busy   (diva_busy[a])
        );
    end

    for (genvar b = 0; b < DIVB_FIELDS; b++) begin : g_divb
        cpuclk_div_field #(.SETTLE_CYC(DIV_SETTLE_CYC)) u_fld (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en && hit.divb),
            .wr_val (wdata[b*FIELD_STRIDE +: FIELD_W]),
            .val    (divb_val[b*FIELD_W +: FIELD_W]),
            .busy   (divb_busy[b])
        );
    end

    always_comb begin
        rd_word = '0;
        if (hit.src) begin
            for (int m = 0; m < MUX_COUNT; m++) begin
                rd_word[MUX_BASE_BIT + m*FIELD_STRIDE] = msel[m];
            end
        end
        if (hit.mstat) begin
            for (int m = 0; m < MUX_COUNT; m++) begin
                rd_word[MUX_BASE_BIT + m*FIELD_STRIDE +: FIELD_W] = mstat[m*FIELD_W +: FIELD_W];
            end
        end
        if (hit.diva) begin
            for (int a = 0; a < DIVA_FIELDS; a++) begin
                rd_word[a*FIELD_STRIDE +: FIELD_W] = diva_val[a*FIELD_W +: FIELD_W];
            end
        end
        if (hit.divb) begin
            for (int b = 0; b < DIVB_FIELDS; b++) begin
                rd_word[b*FIELD_STRIDE +: FIELD_W] = divb_val[b*FIELD_W +: FIELD_W];
            end
        end
        if (hit.dstata) begin
            for (int a = 0; a < DIVA_FIELDS; a++) begin
                rd_word[a*FIELD_STRIDE] = diva_busy[a];
            end
        end
        if (hit.dstatb) begin
            for (int b = 0; b < DIVB_FIELDS; b++) begin
                rd_word[b*FIELD_STRIDE] = divb_busy[b];
            end
        end
    end

    assign rdata = rd_en ? rd_word : '0;

endmodule

// File: rtl/cpuclk_ctl_chk.sv
module cpuclk_ctl_chk
    import cpuclk_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input reg_hit_t    hit,
    input logic [1:0]  msel,
    input logic [5:0]  mstat,
    input logic [20:0] diva_val,
    input logic [6:0]  diva_busy,
    input logic [5:0]  divb_val,
    input logic [1:0]  divb_busy
);

    // R3: core mux status is always one of the three one-hot codes
    p_core_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mstat[2:0]) == 1);

    // R3: a changing core select write enters the in-progress state
    p_core_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit.src && (wdata[16] != msel[0])) |=> (mstat[2:0] == 3'd4));

    // R3: leaving the in-progress state shows the selected source
    p_core_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mstat[2:0]) == 3'd4) && (mstat[2:0] != 3'd4))
        |-> (mstat[2:0] == (msel[0] ? 3'd2 : 3'd1)));

    // R4: a changing monitor select write enters the in-progress state
    p_mon_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit.src && (wdata[20] != msel[1])) |=> (mstat[5:3] == 3'd4));

    // R5: an unchanged core select on a settled mux keeps its status
    p_mux_same_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit.src && (wdata[16] == msel[0]) && (mstat[2:0] != 3'd4))
        |=> $stable(mstat[2:0]));

    // R6: a changed field of divider A goes busy
    p_div_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit.diva && (wdata[2:0] != diva_val[2:0])) |=> diva_busy[0]);

    // R7: an unchanged idle field stays idle
    p_div_same_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit.divb && (wdata[6:4] == divb_val[5:3]) && !divb_busy[1])
        |=> !divb_busy[1]);

    // R9: writes to status offsets leave all control state alone
    p_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (hit.mstat || hit.dstata || hit.dstatb))
        |=> ($stable(diva_val) && $stable(divb_val) && $stable(msel)));

    // R10: undefined offsets read zero
    p_undef_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (hit == '0)) |-> (rdata == '0));

    // R11: no read strobe, no data
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));

endmodule

bind cpuclk_ctl_regs cpuclk_ctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wdata     (wdata),
    .rdata     (rdata),
    .hit       (hit),
    .msel      (msel),
    .mstat     (mstat),
    .diva_val  (diva_val),
    .diva_busy (diva_busy),
    .divb_val  (divb_val),
    .divb_busy (divb_busy)
);

// File: tb/tb_cpuclk_ctl_regs.sv
module tb_cpuclk_ctl_regs;

    localparam int MS = 4;
    localparam int DS = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cpuclk_ctl_regs #(.ADDR_W(12), .MUX_SETTLE_CYC(MS), .DIV_SETTLE_CYC(DS)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // combinational read, takes no clock
    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        #1;
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic chk_rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk_rd("R1 src", 12'h000, 32'h0);
        chk_rd("R1 mstat", 12'h200, 32'h0011_0000);
        chk_rd("R1 diva", 12'h300, 32'h0);
        chk_rd("R1 divb", 12'h304, 32'h0);
        chk_rd("R1 dstata", 12'h400, 32'h0);
        chk_rd("R1 dstatb", 12'h404, 32'h0);
    endtask

    task automatic t_map();
        do_reset();
        wr(12'h000, 32'hFFFF_FFFF);
        wr(12'h300, 32'hFFFF_FFFF);
        wr(12'h304, 32'hFFFF_FFFF);
        chk_rd("R2 src bits", 12'h000, 32'h0011_0000);
        chk_rd("R2 diva fields", 12'h300, 32'h0777_7777);
        chk_rd("R2 divb fields", 12'h304, 32'h0000_0077);
        chk_rd("R2 dstata busy", 12'h400, 32'h0111_1111);
        chk_rd("R2 dstatb busy", 12'h404, 32'h0000_0011);
        repeat (DS) @(negedge clk);
        chk_rd("R2 mstat both alt", 12'h200, 32'h0022_0000);
        chk_rd("R2 dstata idle", 12'h400, 32'h0);
    endtask

    task automatic t_core_mux();
        do_reset();
        wr(12'h000, 32'h0001_0000);
        chk_rd("R3 moving first", 12'h200, 32'h0014_0000);
        repeat (MS - 1) @(negedge clk);
        chk_rd("R3 moving last", 12'h200, 32'h0014_0000);
        @(negedge clk);
        chk_rd("R3 settled alt", 12'h200, 32'h0012_0000);
        wr(12'h000, 32'h0);
        chk_rd("R3 moving back", 12'h200, 32'h0014_0000);
        repeat (MS) @(negedge clk);
        chk_rd("R3 settled primary", 12'h200, 32'h0011_0000);
    endtask

    task automatic t_mon_mux();
        do_reset();
        wr(12'h000, 32'h0010_0000);
        chk_rd("R4 monitor moving", 12'h200, 32'h0041_0000);
        repeat (MS - 1) @(negedge clk);
        chk_rd("R4 monitor last", 12'h200, 32'h0041_0000);
        @(negedge clk);
        chk_rd("R4 monitor alt", 12'h200, 32'h0021_0000);
    endtask

    task automatic t_mux_same();
        do_reset();
        wr(12'h000, 32'h0);
        chk_rd("R5 no transition", 12'h200, 32'h0011_0000);
        wr(12'h000, 32'h0001_0000);
        repeat (MS) @(negedge clk);
        wr(12'h000, 32'h0001_0000);
        chk_rd("R5 alt kept", 12'h200, 32'h0012_0000);
    endtask

    task automatic t_div();
        do_reset();
        wr(12'h300, 32'h0000_0050);
        chk_rd("R6 diva value", 12'h300, 32'h0000_0050);
        chk_rd("R6 field1 busy", 12'h400, 32'h0000_0010);
        repeat (DS - 1) @(negedge clk);
        chk_rd("R6 field1 last", 12'h400, 32'h0000_0010);
        @(negedge clk);
        chk_rd("R6 field1 idle", 12'h400, 32'h0);
        wr(12'h304, 32'h0000_0030);
        chk_rd("R6 divb field1 busy", 12'h404, 32'h0000_0010);
        repeat (DS) @(negedge clk);
        chk_rd("R6 divb idle", 12'h404, 32'h0);
    endtask

    task automatic t_div_same();
        do_reset();
        wr(12'h300, 32'h0000_0050);
        repeat (DS) @(negedge clk);
        wr(12'h300, 32'h0000_0050);
        chk_rd("R7 same value idle", 12'h400, 32'h0);
        wr(12'h300, 32'h0000_0051);
        chk_rd("R7 only field0 busy", 12'h400, 32'h0000_0001);
    endtask

    task automatic t_restart();
        do_reset();
        wr(12'h300, 32'h0300_0000);
        repeat (DS - 1) @(negedge clk);
        wr(12'h300, 32'h0500_0000);
        chk_rd("R8 div restarted", 12'h400, 32'h0100_0000);
        repeat (DS - 1) @(negedge clk);
        chk_rd("R8 div still busy", 12'h400, 32'h0100_0000);
        @(negedge clk);
        chk_rd("R8 div idle", 12'h400, 32'h0);
        chk_rd("R8 div new value", 12'h300, 32'h0500_0000);
        wr(12'h000, 32'h0001_0000);
        repeat (MS - 1) @(negedge clk);
        wr(12'h000, 32'h0);
        repeat (MS - 1) @(negedge clk);
        chk_rd("R8 mux still moving", 12'h200, 32'h0014_0000);
        @(negedge clk);
        chk_rd("R8 mux back primary", 12'h200, 32'h0011_0000);
    endtask

    task automatic t_ro();
        do_reset();
        wr(12'h200, 32'hFFFF_FFFF);
        wr(12'h400, 32'hFFFF_FFFF);
        wr(12'h404, 32'hFFFF_FFFF);
        chk_rd("R9 mstat kept", 12'h200, 32'h0011_0000);
        chk_rd("R9 dstata kept", 12'h400, 32'h0);
        chk_rd("R9 dstatb kept", 12'h404, 32'h0);
        chk_rd("R9 src kept", 12'h000, 32'h0);
        chk_rd("R9 diva kept", 12'h300, 32'h0);
    endtask

    task automatic t_undef();
        do_reset();
        wr(12'h100, 32'hFFFF_FFFF);
        wr(12'h308, 32'hFFFF_FFFF);
        wr(12'h004, 32'hFFFF_FFFF);
        chk_rd("R10 read 0x100", 12'h100, 32'h0);
        chk_rd("R10 read 0x308", 12'h308, 32'h0);
        chk_rd("R10 src untouched", 12'h000, 32'h0);
        chk_rd("R10 diva untouched", 12'h300, 32'h0);
        chk_rd("R10 divb untouched", 12'h304, 32'h0);
        chk_rd("R10 mstat untouched", 12'h200, 32'h0011_0000);
    endtask

    task automatic t_idle();
        do_reset();
        wr(12'h300, 32'h0000_0777);
        addr = 12'h300; rd_en = 1'b0;
        #1;
        check("R11 no strobe", rdata, 32'h0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        t_reset();
        t_map();
        t_core_mux();
        t_mon_mux();
        t_mux_same();
        t_div();
        t_div_same();
        t_restart();
        t_ro();
        t_undef();
        t_idle();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

endmodule